// File: doc/BRIEF.md
# Dual Mode-Selectable Timer/Counter

This block holds two byte-programmed timer/counter units, unit 0 and unit 1, for a small microcontroller. A CPU configures them through a byte-wide special-function-register bus. That bus reaches one mode register, one control register and four count bytes, a low byte and a high byte for each unit. Each unit either advances once for every machine-cycle strobe, which is timer operation, or once for every falling edge of an external pin, which is event counting. The pin for each unit is taken from a group of input pins by a select value.

Each unit has four count arrangements: a 13-bit count, a 16-bit count, an 8-bit count that reloads itself, and a split/stop arrangement. When unit 0 is split, its two bytes count independently of each other. Its high byte then borrows the run bit and the overflow flag of unit 1. Unit 1 in the split/stop arrangement simply freezes. The two overflow flags are also driven on output pins, where an interrupt controller can pick them up.

Top module: `dual_tmr_ctr`

## Requirements
- R1: After reset, every register reads 0x00 and both overflow flags are low.
- R2: Register addresses are as follows: control 0x88, mode 0x89, unit-0 low byte 0x8A, unit-1 low byte 0x8B, unit-0 high byte 0x8C and unit-1 high byte 0x8D. Every one of these reads back what was written, with two exceptions: the control register reads its bits 3:0 as zero, and any other address reads 0x00.
- R3: The mode register holds unit 1 in bits 7:4 and unit 0 in bits 3:0. Within each nibble, from high bit to low bit, the fields are gate, count-select and a 2-bit mode. Mode 00 forms a 13-bit count from the high byte and the low byte's bits 4:0. In that mode the low byte reads bits 7:5 as zero, and stepping past 0x1FFF wraps to zero and sets the unit's flag.
- R4: Mode 01 forms a 16-bit count, high byte over low byte. A low-byte carry increments the high byte, and stepping past 0xFFFF wraps to zero and sets the flag.
- R5: Mode 10 counts the low byte only. When the low byte steps past 0xFF, it is loaded from the high byte and the flag is set. The high byte never changes except by a write.
- R6: Unit 1 in mode 11 holds both of its count bytes.
- R7: Unit 0 in mode 11 splits. Its low byte runs under the unit-0 run bit and sets flag 0 on overflow. Its high byte counts machine-cycle strobes under the unit-1 run bit and sets flag 1 on overflow.
- R8: While unit 0 is split, unit 1 (in any mode except 11) still counts, but its overflow does not set flag 1.
- R9: The control register holds flag 1 at bit 7, run 1 at bit 6, flag 0 at bit 5 and run 0 at bit 4. In timer operation (count-select 0), a unit advances by one on each machine-cycle strobe while its run bit is 1, and it holds while the run bit is 0.
- R10: With count-select 1, a unit advances exactly once for each falling edge of its selected pin, once that edge has passed a two-flop synchronizer. Rising edges, and activity on pins that are not selected, do not count.
- R11: In timer operation with the gate field set, strobes count only while the selected pin (synchronized) is high.
- R12: A flag stays set until software writes it. A control write stores bits 7 and 5 as the new flag values, so writing 1 sets a flag and writing 0 clears it. An overflow in the same cycle as the write wins.
- R13: A write to a unit's count byte in the same cycle as that unit's increment stores the written value, and that increment is lost. In the split arrangement this applies to each half separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mcyc_stb | input | 1 | One-cycle pulse marking each machine cycle |
| sfr_addr | input | 8 | Register address for reads and writes |
| sfr_we | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for sfr_addr, combinational |
| evt_pin | input | NPIN | External event pins |
| t0_pin_sel | input | SELW | Index of the pin that unit 0 uses |
| t1_pin_sel | input | SELW | Index of the pin that unit 1 uses |
| tf0 | output | 1 | Overflow flag of unit 0 |
| tf1 | output | 1 | Overflow flag of unit 1 (or of the split high byte of unit 0) |

## Verification
The assertions take three things for granted. The strobe and the register write lines change only between clock edges. An event pin holds each level for several clock cycles. The pin-select values stay fixed while a unit counts, so the synchronizer never produces two falling-edge pulses in a row. The stimulus keeps to these rules: it holds every pin level for at least four cycles, it makes each strobe exactly one clock wide, and it changes the select values only while no unit is in counting mode. Where the strobe and a register write share a cycle, that overlap is created on purpose, and only to exercise the write-priority rule.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W = 8;
    localparam int PRE_W  = 5;
    localparam int NUNIT  = 2;

    localparam logic [7:0] ADR_TCON = 8'h88;
    localparam logic [7:0] ADR_TMOD = 8'h89;
    localparam logic [7:0] ADR_TL0  = 8'h8A;
    localparam logic [7:0] ADR_TL1  = 8'h8B;
    localparam logic [7:0] ADR_TH0  = 8'h8C;
    localparam logic [7:0] ADR_TH1  = 8'h8D;

    // control register bit positions
    localparam int TF1_BIT = 7;
    localparam int TR1_BIT = 6;
    localparam int TF0_BIT = 5;
    localparam int TR0_BIT = 4;

    typedef enum logic [1:0] {
        MD_13    = 2'b00,
        MD_16    = 2'b01,
        MD_RLD   = 2'b10,
        MD_SPLIT = 2'b11
    } tmr_mode_e;

    // one mode-register nibble, high bit first
    typedef struct packed {
        logic      gate;
        logic      cnt_sel;
        tmr_mode_e mode;
    } unit_cfg_t;

endpackage

// File: rtl/tmr_evt_sync.sv
module tmr_evt_sync #(
    parameter int NPIN = 10,
    parameter int SELW = $clog2(NPIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pins,
    input  logic [SELW-1:0] sel,
    output logic            lvl,
    output logic            fall
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t sy_d, sy_q;
    logic  pick;

    always_comb begin
        pick = 1'b0;
        for (int i = 0; i < NPIN; i++) begin
            if (sel == SELW'(i)) pick = pins[i];
        end
    end

    always_comb begin
        sy_d      = sy_q;
        sy_d.s1   = pick;
        sy_d.s2   = sy_q.s1;
        sy_d.prev = sy_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign lvl  = sy_q.s2;
    assign fall = sy_q.prev & ~sy_q.s2;

    // R10
    fall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter bit SPLIT_OK = 1'b0
) (
    input  tmr_mode_e         mode,
    input  logic [BYTE_W-1:0] tl,
    input  logic [BYTE_W-1:0] th,
    input  logic              inc_lo,
    input  logic              inc_hi,
    output logic [BYTE_W-1:0] tl_nx,
    output logic [BYTE_W-1:0] th_nx,
    output logic              ovf_lo,
    output logic              ovf_hi
);

    localparam int W_PRE  = BYTE_W + PRE_W;
    localparam int W_FULL = 2 * BYTE_W;

    logic              split_lo_inc;
    logic [W_PRE-1:0]  pre_nx;
    logic [W_FULL-1:0] full_nx;

    // only unit 0 keeps its low byte running in the split arrangement
    generate
        if (SPLIT_OK) begin : g_split
            assign split_lo_inc = inc_lo;
        end else begin : g_stop
            assign split_lo_inc = 1'b0;
        end
    endgenerate

    assign pre_nx  = {th, tl[PRE_W-1:0]} + W_PRE'(1);
    assign full_nx = {th, tl} + W_FULL'(1);

    always_comb begin
        tl_nx  = tl;
        th_nx  = th;
        ovf_lo = 1'b0;
        ovf_hi = 1'b0;
        case (mode)
            MD_13: begin
                if (inc_lo) begin
                    tl_nx  = {{(BYTE_W-PRE_W){1'b0}}, pre_nx[PRE_W-1:0]};
                    th_nx  = pre_nx[W_PRE-1:PRE_W];
                    ovf_lo = &{th, tl[PRE_W-1:0]};
                end
            end
            MD_16: begin
                if (inc_lo) begin
                    {th_nx, tl_nx} = full_nx;
                    ovf_lo         = &{th, tl};
                end
            end
            MD_RLD: begin
                if (inc_lo) begin
                    ovf_lo = &tl;
                    tl_nx  = (&tl) ? th : tl + BYTE_W'(1);
                end
            end
            MD_SPLIT: begin
                if (split_lo_inc) begin
                    tl_nx  = tl + BYTE_W'(1);
                    ovf_lo = &tl;
                end
                if (inc_hi) begin
                    th_nx  = th + BYTE_W'(1);
                    ovf_hi = &th;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dual_tmr_ctr.sv
module dual_tmr_ctr
    import tmr_pkg::*;
#(
    parameter int NPIN = 10,
    parameter int SELW = $clog2(NPIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mcyc_stb,
    input  logic [7:0]      sfr_addr,
    input  logic            sfr_we,
    input  logic [7:0]      sfr_wdata,
    output logic [7:0]      sfr_rdata,
    input  logic [NPIN-1:0] evt_pin,
    input  logic [SELW-1:0] t0_pin_sel,
    input  logic [SELW-1:0] t1_pin_sel,
    output logic            tf0,
    output logic            tf1
);

    typedef struct packed {
        unit_cfg_t [NUNIT-1:0]             cfg;
        logic      [NUNIT-1:0]             tr;
        logic      [NUNIT-1:0]             tf;
        logic      [NUNIT-1:0][BYTE_W-1:0] tl;
        logic      [NUNIT-1:0][BYTE_W-1:0] th;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    logic                         wr_tcon, wr_tmod;
    logic [NUNIT-1:0]             wr_tl, wr_th;
    logic [NUNIT-1:0][SELW-1:0]   pin_sel;
    logic [NUNIT-1:0]             lvl, fall, evt;
    logic [NUNIT-1:0]             inc_lo, inc_hi;
    logic [NUNIT-1:0][BYTE_W-1:0] tl_nx, th_nx;
    logic [NUNIT-1:0]             ovf_lo, ovf_hi;
    logic                         split0;
    logic [NUNIT-1:0]             tf_set;

    // ---------------- register decode ----------------
    assign wr_tcon  = sfr_we && (sfr_addr == ADR_TCON);
    assign wr_tmod  = sfr_we && (sfr_addr == ADR_TMOD);
    assign wr_tl[0] = sfr_we && (sfr_addr == ADR_TL0);
    assign wr_tl[1] = sfr_we && (sfr_addr == ADR_TL1);
    assign wr_th[0] = sfr_we && (sfr_addr == ADR_TH0);
    assign wr_th[1] = sfr_we && (sfr_addr == ADR_TH1);

    assign pin_sel[0] = t0_pin_sel;
    assign pin_sel[1] = t1_pin_sel;
    assign split0     = (st_q.cfg[0].mode == MD_SPLIT);

    // ---------------- per-unit event sources and count datapath ----------------
    generate
        for (genvar g = 0; g < NUNIT; g++) begin : g_unit
            tmr_evt_sync #(
                .NPIN (NPIN),
                .SELW (SELW)
            ) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .pins  (evt_pin),
                .sel   (pin_sel[g]),
                .lvl   (lvl[g]),
                .fall  (fall[g])
            );

            tmr_count_core #(
                .SPLIT_OK (g == 0)
            ) u_core (
                .mode   (st_q.cfg[g].mode),
                .tl     (st_q.tl[g]),
                .th     (st_q.th[g]),
                .inc_lo (inc_lo[g]),
                .inc_hi (inc_hi[g]),
                .tl_nx  (tl_nx[g]),
                .th_nx  (th_nx[g]),
                .ovf_lo (ovf_lo[g]),
                .ovf_hi (ovf_hi[g])
            );
        end
    endgenerate

    // ---------------- increment qualification ----------------
    always_comb begin
        for (int u = 0; u < NUNIT; u++) begin
            // counter operation takes pin edges; timer operation takes strobes, optionally pin-gated
            evt[u] = st_q.cfg[u].cnt_sel ? fall[u]
                                         : (mcyc_stb && (!st_q.cfg[u].gate || lvl[u]));
        end
        // unit 0: a write to either byte cancels the step, except that split halves are independent
        inc_lo[0] = st_q.tr[0] && evt[0] && !wr_tl[0] && (split0 || !wr_th[0]);
        inc_hi[0] = split0 && st_q.tr[1] && mcyc_stb && !wr_th[0];
        inc_lo[1] = st_q.tr[1] && evt[1] && !wr_tl[1] && !wr_th[1];
        inc_hi[1] = 1'b0;
    end

    // flag 1 belongs to the high half of unit 0 while it is split; unit 1 never raises ovf_hi
    assign tf_set[0] = ovf_lo[0];
    assign tf_set[1] = split0 ? (ovf_hi[0] | ovf_hi[1]) : ovf_lo[1];

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        if (wr_tmod) begin
            st_d.cfg[1] = unit_cfg_t'(sfr_wdata[7:4]);
            st_d.cfg[0] = unit_cfg_t'(sfr_wdata[3:0]);
        end
        if (wr_tcon) begin
            st_d.tr[1] = sfr_wdata[TR1_BIT];
            st_d.tr[0] = sfr_wdata[TR0_BIT];
            st_d.tf[1] = sfr_wdata[TF1_BIT];
            st_d.tf[0] = sfr_wdata[TF0_BIT];
        end
        for (int u = 0; u < NUNIT; u++) begin
            if (tf_set[u]) st_d.tf[u] = 1'b1;
            st_d.tl[u] = wr_tl[u] ? sfr_wdata : tl_nx[u];
            st_d.th[u] = wr_th[u] ? sfr_wdata : th_nx[u];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // ---------------- read side ----------------
    always_comb begin
        case (sfr_addr)
            ADR_TCON: sfr_rdata = {st_q.tf[1], st_q.tr[1], st_q.tf[0], st_q.tr[0], 4'b0000};
            ADR_TMOD: sfr_rdata = {st_q.cfg[1], st_q.cfg[0]};
            ADR_TL0:  sfr_rdata = (st_q.cfg[0].mode == MD_13)
                                  ? {3'b000, st_q.tl[0][PRE_W-1:0]} : st_q.tl[0];
            ADR_TL1:  sfr_rdata = (st_q.cfg[1].mode == MD_13)
                                  ? {3'b000, st_q.tl[1][PRE_W-1:0]} : st_q.tl[1];
            ADR_TH0:  sfr_rdata = st_q.th[0];
            ADR_TH1:  sfr_rdata = st_q.th[1];
            default:  sfr_rdata = 8'h00;
        endcase
    end

    assign tf0 = st_q.tf[0];
    assign tf1 = st_q.tf[1];

    // ---------------- assertions ----------------
    // R5
    reload_hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg[0].mode == MD_RLD && !wr_th[0]) |=> $stable(st_q.th[0]));

    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg[1].mode == MD_SPLIT && !wr_tl[1] && !wr_th[1])
        |=> ($stable(st_q.tl[1]) && $stable(st_q.th[1])));

    // R8
    split_flag_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (split0 && !st_q.tf[1] && !wr_tcon && !(st_q.tr[1] && mcyc_stb)) |=> !st_q.tf[1]);

    // R9
    run_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!split0 && !st_q.tr[0] && !wr_tl[0] && !wr_th[0])
        |=> ($stable(st_q.tl[0]) && $stable(st_q.th[0])));

    // R12
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tf[0] && !(wr_tcon && !sfr_wdata[TF0_BIT])) |=> st_q.tf[0]);

    // R13
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tl[0] |=> (st_q.tl[0] == $past(sfr_wdata)));

endmodule

// File: tb/tb_dual_tmr_ctr.sv
module tb_dual_tmr_ctr;

    localparam int NPIN = 10;
    localparam int SELW = $clog2(NPIN);
    localparam logic [7:0] A_TCON = 8'h88, A_TMOD = 8'h89, A_TL0 = 8'h8A,
                           A_TL1 = 8'h8B, A_TH0 = 8'h8C, A_TH1 = 8'h8D;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mcyc_stb = 1'b0;
    logic [7:0]      sfr_addr = 8'h00;
    logic            sfr_we = 1'b0;
    logic [7:0]      sfr_wdata = 8'h00;
    logic [7:0]      sfr_rdata;
    logic [NPIN-1:0] evt_pin = '0;
    logic [SELW-1:0] t0_pin_sel = SELW'(3);
    logic [SELW-1:0] t1_pin_sel = SELW'(6);
    logic            tf0, tf1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] addr;
        logic [7:0] exp;
        bit         flg;
        string      tag;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    dual_tmr_ctr #(.NPIN(NPIN)) dut (
        .clk(clk), .rst_n(rst_n), .mcyc_stb(mcyc_stb),
        .sfr_addr(sfr_addr), .sfr_we(sfr_we), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .evt_pin(evt_pin), .t0_pin_sel(t0_pin_sel), .t1_pin_sel(t1_pin_sel),
        .tf0(tf0), .tf1(tf1)
    );

    // monitor: pops expected items and compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                act = it.flg ? {6'b0, tf1, tf0} : sfr_rdata;
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s addr=%02h actual=%02h expected=%02h", it.tag, it.addr, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
        @(posedge clk); #1;
        sfr_we = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; mcyc_stb = 1'b1;
            @(posedge clk); #1; mcyc_stb = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // driver: pushes the expected register value, monitor compares it
    task automatic chk(input logic [7:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        sfr_addr = a;
        it.addr = a; it.exp = e; it.flg = 1'b0; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    // expected {tf1, tf0}
    task automatic chkf(input logic [1:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.addr = 8'hFF; it.exp = {6'b0, e}; it.flg = 1'b1; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic pin_level(input int idx, input logic v);
        @(posedge clk); #1;
        evt_pin[idx] = v;
        idle(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk(A_TCON, 8'h00, "R1 control");
        chk(A_TMOD, 8'h00, "R1 mode");
        chk(A_TL0, 8'h00, "R1 tl0");
        chk(A_TH1, 8'h00, "R1 th1");
        chkf(2'b00, "R1 flags");

        // R2 register map
        wr(A_TH1, 8'hA5);
        chk(A_TH1, 8'hA5, "R2 th1 readback");
        wr(A_TMOD, 8'hC6);
        chk(A_TMOD, 8'hC6, "R2 mode readback");
        wr(A_TCON, 8'h5F);
        chk(A_TCON, 8'h50, "R2 control low nibble zero");
        wr(A_TCON, 8'h00);
        wr(A_TMOD, 8'h00);
        chk(8'h90, 8'h00, "R2 unmapped address");

        // R3 13-bit mode, unit 0 timer
        wr(A_TL0, 8'hFE);
        chk(A_TL0, 8'h1E, "R3 low byte masked");
        wr(A_TH0, 8'hFF);
        wr(A_TCON, 8'h10);
        pulse(1);
        chk(A_TL0, 8'h1F, "R3 step");
        chkf(2'b00, "R3 no flag before wrap");
        pulse(1);
        chk(A_TL0, 8'h00, "R3 wrap low");
        chk(A_TH0, 8'h00, "R3 wrap high");
        chk(A_TCON, 8'h30, "R3 flag in control");
        wr(A_TCON, 8'h00);
        chkf(2'b00, "R12 flag cleared by write 0");

        // R4 16-bit mode
        wr(A_TMOD, 8'h01);
        wr(A_TL0, 8'hFF);
        wr(A_TH0, 8'h12);
        wr(A_TCON, 8'h10);
        pulse(1);
        chk(A_TL0, 8'h00, "R4 carry low");
        chk(A_TH0, 8'h13, "R4 carry high");
        chkf(2'b00, "R4 no flag on carry");
        wr(A_TL0, 8'hFF);
        wr(A_TH0, 8'hFF);
        pulse(1);
        chk(A_TH0, 8'h00, "R4 wrap high");
        chkf(2'b01, "R4 flag on wrap");
        wr(A_TCON, 8'h00);

        // R5 auto reload
        wr(A_TMOD, 8'h02);
        wr(A_TH0, 8'hF0);
        wr(A_TL0, 8'hFE);
        wr(A_TCON, 8'h10);
        pulse(2);
        chk(A_TL0, 8'hF0, "R5 reloaded");
        chk(A_TH0, 8'hF0, "R5 high unchanged");
        chkf(2'b01, "R5 flag");
        pulse(1);
        chk(A_TL0, 8'hF1, "R5 resumes after reload");
        wr(A_TCON, 8'h00);

        // R9 run bit
        wr(A_TMOD, 8'h01);
        wr(A_TH0, 8'h00);
        wr(A_TL0, 8'h05);
        pulse(3);
        chk(A_TL0, 8'h05, "R9 held with run off");
        wr(A_TCON, 8'h10);
        idle(5);
        chk(A_TL0, 8'h05, "R9 no count without strobe");
        pulse(3);
        chk(A_TL0, 8'h08, "R9 counts strobes");

        // R13 write beats increment
        @(posedge clk); #1;
        mcyc_stb = 1'b1; sfr_we = 1'b1; sfr_addr = A_TL0; sfr_wdata = 8'h40;
        @(posedge clk); #1;
        mcyc_stb = 1'b0; sfr_we = 1'b0;
        chk(A_TL0, 8'h40, "R13 written value kept");
        chk(A_TH0, 8'h00, "R13 high untouched");

        // R11 gated timer on pin 3
        wr(A_TCON, 8'h00);
        wr(A_TMOD, 8'h09);
        wr(A_TL0, 8'h00);
        wr(A_TCON, 8'h10);
        pulse(2);
        chk(A_TL0, 8'h00, "R11 gate closed");
        pin_level(3, 1'b1);
        pulse(3);
        chk(A_TL0, 8'h03, "R11 gate open");
        pin_level(3, 1'b0);
        pulse(2);
        chk(A_TL0, 8'h03, "R11 gate closed again");

        // R10 event counting on pin 3
        wr(A_TMOD, 8'h05);
        wr(A_TL0, 8'h00);
        for (int k = 0; k < 4; k++) begin
            pin_level(3, 1'b1);
            pin_level(3, 1'b0);
        end
        idle(2);
        chk(A_TL0, 8'h04, "R10 four falling edges");
        pin_level(3, 1'b1);
        idle(2);
        chk(A_TL0, 8'h04, "R10 rising edge ignored");
        pin_level(5, 1'b1);
        pin_level(5, 1'b0);
        idle(2);
        chk(A_TL0, 8'h04, "R10 other pin ignored");
        pin_level(3, 1'b0);
        idle(2);
        chk(A_TL0, 8'h05, "R10 next falling edge");
        wr(A_TCON, 8'h00);

        // R6 unit 1 stopped
        wr(A_TMOD, 8'h30);
        wr(A_TL1, 8'h07);
        wr(A_TCON, 8'h40);
        pulse(3);
        chk(A_TL1, 8'h07, "R6 unit 1 holds");

        // R7 split unit 0
        wr(A_TMOD, 8'h13);
        wr(A_TCON, 8'h10);
        wr(A_TL0, 8'hFE);
        wr(A_TH0, 8'hFD);
        pulse(2);
        chk(A_TL0, 8'h00, "R7 low half wraps");
        chk(A_TH0, 8'hFD, "R7 high half idle without run 1");
        chkf(2'b01, "R7 low half sets flag 0");
        wr(A_TCON, 8'h40);
        pulse(3);
        chk(A_TH0, 8'h00, "R7 high half wraps");
        chk(A_TL0, 8'h00, "R7 low half idle without run 0");
        chkf(2'b10, "R7 high half sets flag 1");
        chk(A_TL1, 8'h0A, "R8 unit 1 keeps counting");

        // R8 unit 1 overflow does not reach flag 1 while split
        wr(A_TCON, 8'h40);
        wr(A_TL1, 8'hFF);
        wr(A_TH1, 8'hFF);
        wr(A_TH0, 8'h00);
        pulse(1);
        chk(A_TL1, 8'h00, "R8 unit 1 wrapped");
        chk(A_TH0, 8'h01, "R8 high half stepped");
        chkf(2'b00, "R8 no flag from unit 1");

        // unsplit: unit 1 owns flag 1 again, then R12 stickiness
        wr(A_TMOD, 8'h10);
        wr(A_TL1, 8'hFF);
        wr(A_TH1, 8'hFF);
        pulse(1);
        chkf(2'b10, "R8 flag 1 back with unit 1");
        wr(A_TCON, 8'h00);
        wr(A_TCON, 8'h80);
        idle(10);
        chkf(2'b10, "R12 flag stays set");
        wr(A_TCON, 8'h60);
        chkf(2'b01, "R12 write sets flag 0 and clears flag 1");
        wr(A_TCON, 8'h00);
        chkf(2'b00, "R12 both cleared");

        idle(3);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule